// File: doc/BRIEF.md
# USB Endpoint Receive Descriptor Engine

This block sits behind a full-speed USB device serial interface engine. It takes decoded tokens and data bytes and stores the bytes of each OUT or SETUP data packet into a chain of receive buffer descriptors. The descriptors live in a small local table, with one group of slots per endpoint. The engine keeps a running buffer pointer and a down-counting remaining-byte count. Full buffers are closed and chaining continues into the next descriptor. At end of packet the engine closes the partial buffer, writes the error status into the last descriptor it used, and asks for an ACK handshake only if the packet arrived clean. A start-of-frame token latches the frame number and raises a maskable interrupt.

Each descriptor is 30 bits: bit 29 empty (E), bit 28 wrap (W), bit 27 interrupt enable (I), bit 26 last-in-packet (L), bit 25 CRC error, bit 24 bit-stuff error, bits 23:12 byte length, and bits 11:0 buffer start address. Descriptor table index = endpoint * BD_PER_EP + slot. Token kinds on `tok_kind` are 0 = OUT, 1 = SETUP, 2 = SOF and 3 = other (ignored).

The controller is one state machine:
- IDLE: a data token moves it to FETCH. A SETUP token on a non-control endpoint moves it to DROP instead.
- FETCH: reads the endpoint's current descriptor. If E is set it goes to FILL. If the descriptor was reached through a spill, the held byte is written in this same cycle. If E is clear it pulses busy and goes to DROP.
- FILL: stores bytes. The byte that empties the count moves it to SPILL. End of packet moves it to CLOSE.
- SPILL: closes the full buffer and goes to FULL.
- FULL: a further byte is held, the slot advances, and it returns to FETCH. End of packet moves it to CLOSE.
- CLOSE: writes length, L and the error flags, pulses the interrupt and ACK, advances the slot, and returns to IDLE.
- DROP: waits for end of packet, then returns to IDLE.

Top module: `usb_rx_bd_engine`

## Requirements
- R1: A SETUP token (kind 1) on an endpoint whose `ctrl_ep_mask` bit is 0 stores no byte, sends no ACK, raises no busy and leaves every descriptor unchanged.
- R2: The engine fetches the endpoint's current descriptor one cycle after an OUT (kind 0) or SETUP token. Bytes are stored only into a descriptor whose E bit (29) is 1.
- R3: Every packet byte, including the leading PID byte, appears once on the buffer write port in arrival order. The address is the descriptor start address plus the byte's offset within that buffer. The remaining count starts at `max_buf_len` and never reaches zero while filling.
- R4: When a buffer receives `max_buf_len` bytes, its descriptor gets E = 0 and length = `max_buf_len`. `rx_irq` pulses if its I bit (27) is 1.
- R5: Bytes beyond a full buffer go into the endpoint's next descriptor, starting at that descriptor's start address, provided its E bit is 1.
- R6: At an error-free end of packet, the last descriptor gets E = 0, L (bit 26) = 1 and length = bytes stored in it. `ack_req` pulses for one cycle. `rx_irq` pulses if I = 1, unless that buffer already raised it when it filled.
- R7: At end of packet with a CRC or bit-stuff error, no ACK is requested. Bit 25 (CRC) and bit 24 (stuff) are set in the last descriptor the packet used. Earlier full descriptors of that packet carry no error bits.
- R8: If a descriptor that must receive data has E = 0, `rx_busy` pulses. The rest of the packet is discarded, no ACK is requested, and that descriptor is left unchanged.
- R9: Each endpoint keeps its own slot index. After a descriptor with W (bit 28) = 1, or after the last slot, the index returns to slot 0 of that endpoint.
- R10: A SOF token (kind 2) loads `tok_frame` into `frame_num` one cycle later. `sof_irq` pulses in that same cycle only if `sof_irq_en` is 1.
- R11: After reset all outputs are 0, `frame_num` is 0, and every descriptor reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token kind (0 OUT, 1 SETUP, 2 SOF, 3 other) |
| tok_ep | input | 2 | Token endpoint number |
| tok_frame | input | 11 | Frame number carried by a SOF token |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_crc_err | input | 1 | CRC error, valid with rx_eop |
| rx_stuff_err | input | 1 | Bit-stuff error, valid with rx_eop |
| ctrl_ep_mask | input | 4 | One bit per endpoint, 1 = control endpoint |
| max_buf_len | input | 12 | Receive buffer length in bytes (at least 1) |
| sof_irq_en | input | 1 | SOF interrupt mask bit |
| bd_ld_en | input | 1 | Descriptor table load strobe |
| bd_ld_idx | input | 4 | Descriptor table index to load |
| bd_ld_data | input | 30 | Descriptor value to load |
| bd_rd_idx | input | 4 | Descriptor table index to read |
| bd_rd_data | output | 30 | Descriptor value at bd_rd_idx |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 12 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| rx_irq | output | 1 | Receive buffer interrupt pulse |
| ack_req | output | 1 | ACK handshake request pulse |
| rx_busy | output | 1 | Busy (no empty descriptor) pulse |
| sof_irq | output | 1 | SOF interrupt pulse |
| frame_num | output | 11 | Latest frame number |

## Verification
A byte's buffer write is due in the same cycle as its strobe. The exception is the first byte after a full buffer: it is held and written in the FETCH cycle one cycle later. Descriptor closes, `rx_irq` and `ack_req` land one cycle after the filling byte or the end-of-packet strobe. `rx_busy` lands one cycle after the token or the held byte. `frame_num` and `sof_irq` land one cycle after the SOF token. The bench changes inputs just after the rising edge and samples in mid-cycle at the falling edge. On every clock it compares each buffer write against a queue predicted by a behavioural model and counts the pulses. It reads back the whole descriptor table only several cycles after end of packet, so every close has already landed.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
    parameter int unsigned ADDR_W  = 12;
    parameter int unsigned LEN_W   = 12;
    parameter int unsigned FRAME_W = 11;

    // Receive buffer descriptor, most significant field first.
    typedef struct packed {
        logic              empty;
        logic              wrap;
        logic              irq_en;
        logic              last;
        logic              crc_err;
        logic              stf_err;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] ptr;
    } bd_t;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_SETUP = 2'd1,
        TOK_SOF   = 2'd2,
        TOK_OTHER = 2'd3
    } tok_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_FILL, S_SPILL, S_FULL, S_CLOSE, S_DROP
    } rx_state_e;
endpackage

// File: rtl/usb_rx_bd_mem.sv
module usb_rx_bd_mem #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 30,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IW-1:0]    ld_idx,
    input  logic [WIDTH-1:0] ld_data,
    input  logic             up_en,
    input  logic [IW-1:0]    up_idx,
    input  logic [WIDTH-1:0] up_data,
    input  logic [IW-1:0]    ra_idx,
    output logic [WIDTH-1:0] ra_data,
    input  logic [IW-1:0]    rb_idx,
    output logic [WIDTH-1:0] rb_data
);
    logic [WIDTH-1:0] table_q [DEPTH];

    // Engine updates win over external loads in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) table_q[i] <= '0;
        end else if (up_en) begin
            table_q[up_idx] <= up_data;
        end else if (ld_en) begin
            table_q[ld_idx] <= ld_data;
        end
    end

    assign ra_data = table_q[ra_idx];
    assign rb_data = table_q[rb_idx];
endmodule

// File: rtl/usb_rx_sof.sv
module usb_rx_sof #(
    parameter int unsigned FW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof_seen,
    input  logic [FW-1:0] frame_in,
    input  logic          irq_en,
    output logic [FW-1:0] frame_q,
    output logic          irq_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= sof_seen && irq_en;
            if (sof_seen) frame_q <= frame_in;
        end
    end

    assert_sof_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(sof_seen && irq_en));
    assert_frame_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(sof_seen) |-> $stable(frame_q));
endmodule

// File: rtl/usb_rx_bd_engine.sv
module usb_rx_bd_engine
    import usb_rx_pkg::*;
#(
    parameter int unsigned NUM_EP    = 4,
    parameter int unsigned BD_PER_EP = 4,
    localparam int unsigned EP_W   = $clog2(NUM_EP),
    localparam int unsigned SLOT_W = $clog2(BD_PER_EP),
    localparam int unsigned IDX_W  = $clog2(NUM_EP * BD_PER_EP),
    localparam int unsigned BD_W   = $bits(bd_t)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tok_valid,
    input  logic [1:0]         tok_kind,
    input  logic [EP_W-1:0]    tok_ep,
    input  logic [FRAME_W-1:0] tok_frame,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_eop,
    input  logic               rx_crc_err,
    input  logic               rx_stuff_err,
    input  logic [NUM_EP-1:0]  ctrl_ep_mask,
    input  logic [LEN_W-1:0]   max_buf_len,
    input  logic               sof_irq_en,
    input  logic               bd_ld_en,
    input  logic [IDX_W-1:0]   bd_ld_idx,
    input  logic [BD_W-1:0]    bd_ld_data,
    input  logic [IDX_W-1:0]   bd_rd_idx,
    output logic [BD_W-1:0]    bd_rd_data,
    output logic               buf_we,
    output logic [ADDR_W-1:0]  buf_addr,
    output logic [7:0]         buf_wdata,
    output logic               rx_irq,
    output logic               ack_req,
    output logic               rx_busy,
    output logic               sof_irq,
    output logic [FRAME_W-1:0] frame_num
);
    rx_state_e         state_q, state_d;
    tok_e              kind;
    logic [SLOT_W-1:0] slot_q [NUM_EP];
    logic [SLOT_W-1:0] next_slot;
    logic [EP_W-1:0]   ep_q;
    bd_t               cur_q, fetch_bd, upd_bd;
    logic [BD_W-1:0]   fetch_raw;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [7:0]        held_q;
    logic              held_v_q, full_q, crc_q, stf_q, upd_en;

    assign kind      = tok_e'(tok_kind);
    assign fetch_bd  = bd_t'(fetch_raw);
    assign cur_idx   = IDX_W'(int'(ep_q) * BD_PER_EP + int'(slot_q[ep_q]));
    assign next_slot = (cur_q.wrap || slot_q[ep_q] == SLOT_W'(BD_PER_EP - 1))
                       ? '0 : slot_q[ep_q] + SLOT_W'(1);

    usb_rx_bd_mem #(.DEPTH(NUM_EP * BD_PER_EP), .WIDTH(BD_W)) bd_mem_i (
        .clk(clk), .rst_n(rst_n),
        .ld_en(bd_ld_en), .ld_idx(bd_ld_idx), .ld_data(bd_ld_data),
        .up_en(upd_en), .up_idx(cur_idx), .up_data(upd_bd),
        .ra_idx(cur_idx), .ra_data(fetch_raw),
        .rb_idx(bd_rd_idx), .rb_data(bd_rd_data)
    );

    usb_rx_sof #(.FW(FRAME_W)) sof_i (
        .clk(clk), .rst_n(rst_n),
        .sof_seen(tok_valid && kind == TOK_SOF), .frame_in(tok_frame),
        .irq_en(sof_irq_en), .frame_q(frame_num), .irq_q(sof_irq)
    );

    // State register and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            ep_q     <= '0;
            cur_q    <= '0;
            ptr_q    <= '0;
            cnt_q    <= '0;
            held_q   <= '0;
            held_v_q <= 1'b0;
            full_q   <= 1'b0;
            crc_q    <= 1'b0;
            stf_q    <= 1'b0;
            for (int e = 0; e < NUM_EP; e++) slot_q[e] <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (tok_valid) begin
                    ep_q     <= tok_ep;
                    held_v_q <= 1'b0;
                    full_q   <= 1'b0;
                    crc_q    <= 1'b0;
                    stf_q    <= 1'b0;
                end
                S_FETCH: if (fetch_bd.empty) begin
                    cur_q    <= fetch_bd;
                    ptr_q    <= fetch_bd.ptr + ADDR_W'(held_v_q);
                    cnt_q    <= max_buf_len - LEN_W'(held_v_q);
                    full_q   <= 1'b0;
                    held_v_q <= 1'b0;
                end
                S_FILL: if (rx_valid) begin
                    ptr_q <= ptr_q + ADDR_W'(1);
                    cnt_q <= cnt_q - LEN_W'(1);
                end else if (rx_eop) begin
                    crc_q <= rx_crc_err;
                    stf_q <= rx_stuff_err;
                end
                S_SPILL: full_q <= 1'b1;
                S_FULL: if (rx_valid) begin
                    held_q       <= rx_data;
                    held_v_q     <= 1'b1;
                    slot_q[ep_q] <= next_slot;
                end else if (rx_eop) begin
                    crc_q <= rx_crc_err;
                    stf_q <= rx_stuff_err;
                end
                S_CLOSE: slot_q[ep_q] <= next_slot;
                S_DROP: ;
                default: ;
            endcase
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        buf_we    = 1'b0;
        buf_addr  = ptr_q;
        buf_wdata = rx_data;
        upd_en    = 1'b0;
        upd_bd    = cur_q;
        rx_irq    = 1'b0;
        ack_req   = 1'b0;
        rx_busy   = 1'b0;
        unique case (state_q)
            S_IDLE: if (tok_valid && (kind == TOK_OUT || kind == TOK_SETUP)) begin
                if (kind == TOK_SETUP && !ctrl_ep_mask[tok_ep]) state_d = S_DROP;
                else                                             state_d = S_FETCH;
            end
            S_FETCH: if (fetch_bd.empty) begin
                state_d = S_FILL;
                if (held_v_q) begin
                    buf_we    = 1'b1;
                    buf_addr  = fetch_bd.ptr;
                    buf_wdata = held_q;
                    if (max_buf_len == LEN_W'(1)) state_d = S_SPILL;
                end
            end else begin
                rx_busy = 1'b1;
                state_d = S_DROP;
            end
            S_FILL: if (rx_valid) begin
                buf_we = 1'b1;
                if (cnt_q == LEN_W'(1)) state_d = S_SPILL;
            end else if (rx_eop) begin
                state_d = S_CLOSE;
            end
            S_SPILL: begin
                upd_en       = 1'b1;
                upd_bd.empty = 1'b0;
                upd_bd.len   = max_buf_len;
                rx_irq       = cur_q.irq_en;
                state_d      = S_FULL;
            end
            S_FULL: if (rx_valid)    state_d = S_FETCH;
                    else if (rx_eop) state_d = S_CLOSE;
            S_CLOSE: begin
                upd_en         = 1'b1;
                upd_bd.empty   = 1'b0;
                upd_bd.last    = 1'b1;
                upd_bd.crc_err = crc_q;
                upd_bd.stf_err = stf_q;
                upd_bd.len     = max_buf_len - cnt_q;
                rx_irq         = cur_q.irq_en && !full_q;
                ack_req        = !crc_q && !stf_q;
                state_d        = S_IDLE;
            end
            S_DROP: if (rx_eop) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assert_setup_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && tok_valid && kind == TOK_SETUP && !ctrl_ep_mask[tok_ep])
        |=> (state_q == S_DROP));
    assert_store_needs_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && state_q == S_FETCH) |-> fetch_bd.empty);
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q == S_FILL) && $past(buf_we))
        |-> ptr_q == $past(ptr_q) + ADDR_W'(1));
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q == S_FILL) && $past(buf_we))
        |-> cnt_q == $past(cnt_q) - LEN_W'(1));
    assert_cnt_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL) |-> (cnt_q != '0));
    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !ack_req);
    assert_busy_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> (state_q == S_DROP));
endmodule

// File: tb/usb_rx_bd_engine_tb.sv
module usb_rx_bd_engine_tb_top;
    localparam int NBD = 16;
    localparam int BPE = 4;
    localparam int MRB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 0, rx_valid = 0, rx_eop = 0, rx_crc_err = 0, rx_stuff_err = 0;
    logic [1:0]  tok_kind = 0, tok_ep = 0;
    logic [10:0] tok_frame = 0;
    logic [7:0]  rx_data = 0;
    logic [3:0]  ctrl_ep_mask = 4'b0001;
    logic [11:0] max_buf_len = 12'(MRB);
    logic        sof_irq_en = 1'b1, bd_ld_en = 1'b0;
    logic [3:0]  bd_ld_idx = 0, bd_rd_idx = 0;
    logic [29:0] bd_ld_data = 0, bd_rd_data;
    logic        buf_we, rx_irq, ack_req, rx_busy, sof_irq;
    logic [11:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic [10:0] frame_num;

    usb_rx_bd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_ep(tok_ep), .tok_frame(tok_frame), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eop(rx_eop), .rx_crc_err(rx_crc_err), .rx_stuff_err(rx_stuff_err),
        .ctrl_ep_mask(ctrl_ep_mask), .max_buf_len(max_buf_len), .sof_irq_en(sof_irq_en),
        .bd_ld_en(bd_ld_en), .bd_ld_idx(bd_ld_idx), .bd_ld_data(bd_ld_data),
        .bd_rd_idx(bd_rd_idx), .bd_rd_data(bd_rd_data), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .rx_irq(rx_irq), .ack_req(ack_req),
        .rx_busy(rx_busy), .sof_irq(sof_irq), .frame_num(frame_num)
    );

    always #2 clk = ~clk;  // 250 MHz

    int n_chk = 0, n_err = 0;
    bit done = 0, mon_on = 0;
    string cur_req = "R3";
    int o_ack, o_irq, o_busy, o_sof, e_ack, e_irq, e_busy;
    int exp_addr[$], exp_data[$];

    // Behavioural descriptor model
    bit m_e[NBD], m_w[NBD], m_i[NBD], m_l[NBD], m_c[NBD], m_s[NBD];
    int m_len[NBD], m_ptr[NBD], m_slot[4];

    function automatic logic [29:0] pack(int i);
        return {m_e[i], m_w[i], m_i[i], m_l[i], m_c[i], m_s[i], 12'(m_len[i]), 12'(m_ptr[i])};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Cycle monitor: every write compared to the model queue, pulses counted.
    always @(negedge clk) if (mon_on) begin
        if (buf_we) begin
            if (exp_addr.size() == 0) begin
                chk(0, cur_req, "unexpected buffer write addr", int'(buf_addr), -1);
            end else begin
                int a, d;
                a = exp_addr.pop_front();
                d = exp_data.pop_front();
                chk(int'(buf_addr) == a && int'(buf_wdata) == d, cur_req,
                    "buffer write addr/data", int'({buf_addr, buf_wdata}), (a << 8) | d);
            end
        end
        if (ack_req) o_ack++;
        if (rx_irq)  o_irq++;
        if (rx_busy) o_busy++;
        if (sof_irq) o_sof++;
    end

    task automatic load_bd(int idx, bit e, bit w, bit i, int ptr);
        m_e[idx] = e; m_w[idx] = w; m_i[idx] = i; m_l[idx] = 0; m_c[idx] = 0; m_s[idx] = 0;
        m_len[idx] = 0; m_ptr[idx] = ptr;
        bd_ld_en = 1; bd_ld_idx = 4'(idx); bd_ld_data = pack(idx);
        tick();
        bd_ld_en = 0;
    endtask

    function automatic void adv(int ep, int cur);
        if (m_w[cur] || m_slot[ep] == BPE - 1) m_slot[ep] = 0;
        else m_slot[ep]++;
    endfunction

    task automatic check_table(string req);
        for (int k = 0; k < NBD; k++) begin
            bd_rd_idx = 4'(k);
            #0.1;
            chk(bd_rd_data == pack(k), req, $sformatf("descriptor %0d", k),
                int'(bd_rd_data), int'(pack(k)));
        end
    endtask

    task automatic run_pkt(int kind, int ep, int nb, int seed, bit crc, bit stf, string req);
        int cur, off;
        bit full, drop;
        e_ack = 0; e_irq = 0; e_busy = 0; o_ack = 0; o_irq = 0; o_busy = 0;
        cur_req = req;
        // model
        if (!(kind == 1 && !ctrl_ep_mask[ep])) begin
            cur = ep * BPE + m_slot[ep];
            off = 0; full = 0; drop = 0;
            if (!m_e[cur]) begin e_busy++; drop = 1; end
            for (int k = 0; k < nb && !drop; k++) begin
                if (full) begin
                    adv(ep, cur);
                    cur = ep * BPE + m_slot[ep];
                    if (!m_e[cur]) begin e_busy++; drop = 1; break; end
                    off = 0; full = 0;
                end
                exp_addr.push_back(m_ptr[cur] + off);
                exp_data.push_back(k == 0 ? 8'hC3 : (seed + k * 7) & 255);
                off++;
                if (off == MRB) begin
                    m_e[cur] = 0; m_len[cur] = MRB; full = 1;
                    if (m_i[cur]) e_irq++;
                end
            end
            if (!drop) begin
                m_e[cur] = 0; m_l[cur] = 1; m_len[cur] = off; m_c[cur] = crc; m_s[cur] = stf;
                if (m_i[cur] && !full) e_irq++;
                if (!crc && !stf) e_ack++;
                adv(ep, cur);
            end
        end
        // stimulus
        tok_valid = 1; tok_kind = 2'(kind); tok_ep = 2'(ep);
        tick();
        tok_valid = 0;
        tick(); tick();
        for (int k = 0; k < nb; k++) begin
            rx_valid = 1; rx_data = (k == 0) ? 8'hC3 : 8'((seed + k * 7) & 255);
            tick();
            rx_valid = 0;
            tick(); tick(); tick();
        end
        rx_eop = 1; rx_crc_err = crc; rx_stuff_err = stf;
        tick();
        rx_eop = 0; rx_crc_err = 0; rx_stuff_err = 0;
        repeat (6) tick();
        chk(exp_addr.size() == 0, req, "writes left outstanding", exp_addr.size(), 0);
        chk(o_ack == e_ack, req, "ack pulses", o_ack, e_ack);
        chk(o_irq == e_irq, req, "irq pulses", o_irq, e_irq);
        chk(o_busy == e_busy, "R8", "busy pulses", o_busy, e_busy);
        check_table(req);
    endtask

    initial begin
        #400000;
        chk(0, "ALL", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int k = 0; k < NBD; k++) begin
            m_e[k] = 0; m_w[k] = 0; m_i[k] = 0; m_l[k] = 0; m_c[k] = 0; m_s[k] = 0;
            m_len[k] = 0; m_ptr[k] = 0;
        end
        for (int e = 0; e < 4; e++) m_slot[e] = 0;
        repeat (3) tick();
        // R11: reset state
        chk({buf_we, rx_irq, ack_req, rx_busy, sof_irq} == 0, "R11", "pulse outputs", 0, 0);
        chk(frame_num == 0, "R11", "frame_num", int'(frame_num), 0);
        rst_n = 1;
        tick();
        check_table("R11");
        mon_on = 1;

        load_bd(0, 1, 0, 1, 12'h100);
        load_bd(1, 1, 0, 1, 12'h200);
        load_bd(2, 1, 1, 0, 12'h300);
        load_bd(4, 1, 1, 1, 12'h400);
        load_bd(8, 1, 0, 1, 12'h500);
        load_bd(9, 0, 0, 1, 12'h600);

        run_pkt(0, 0, 5, 17, 0, 0, "R6");   // R2 R3: short OUT into one buffer
        run_pkt(1, 1, 4, 33, 0, 0, "R1");   // SETUP on non-control endpoint
        run_pkt(1, 0, 12, 90, 0, 0, "R5");  // R4 spill then close, wrap R9
        load_bd(0, 1, 0, 1, 12'h180);
        run_pkt(0, 0, 3, 5, 1, 0, "R7");    // CRC error, wrapped slot R9
        run_pkt(0, 1, 8, 61, 0, 1, "R4");   // exact fill plus stuff error R7
        run_pkt(0, 2, 10, 11, 0, 0, "R8");  // spill into non-empty descriptor
        run_pkt(0, 0, 2, 3, 0, 0, "R2");    // current descriptor not empty

        // R10: SOF handling
        o_sof = 0;
        sof_irq_en = 1; tok_valid = 1; tok_kind = 2'd2; tok_frame = 11'h5A3;
        tick();
        tok_valid = 0;
        chk(frame_num == 11'h5A3, "R10", "frame_num", int'(frame_num), 'h5A3);
        tick();
        chk(o_sof == 1, "R10", "sof pulse enabled", o_sof, 1);
        sof_irq_en = 0; tok_valid = 1; tok_frame = 11'h07F;
        tick();
        tok_valid = 0;
        chk(frame_num == 11'h07F, "R10", "frame_num masked", int'(frame_num), 'h07F);
        repeat (2) tick();
        chk(o_sof == 1, "R10", "sof pulse masked", o_sof, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule